// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer

This block is a 16-bit watchdog down-counter set up through four byte-wide configuration registers. It takes a one-second tick from elsewhere in the chip. Depending on a configuration bit, it decrements once per tick or once every sixty ticks. Software arms and refreshes the watchdog by writing the count. Writing a count of zero stops it. When the count reaches zero, the block sets a sticky status flag. It can also fire a fixed-width reset pulse, a fixed-width power-good pulse and a level interrupt request, each gated by its own enable bit.

The register access path is outside this block. The block receives a byte write strobe with an address and data. It returns read data for the address currently presented. A write to the count high byte is only staged. A write to the low byte combines it with the staged high byte and reloads the counter. After an expiry the counter stays at zero until it is written again.

Top module: `sm_watchdog`

## Requirements
- R1: After reset all outputs are low, and every register (control 0x71, configuration 0x72, count low 0x73, count high 0x74) reads as zero.
- R2: A write to 0x74 only stages the high byte, and the count read back does not change. A write to 0x73 loads the counter with {staged high byte, written low byte} on that clock edge.
- R3: With configuration bit 7 set (seconds), the running count drops by exactly one for each tick.
- R4: With configuration bit 7 clear (minutes), the running count drops by one on every 60th tick. Any write to 0x73 clears the tick prescaler.
- R5: Writing a count of zero stops the watchdog. Later ticks change nothing, and no expiry follows.
- R6: When a running count reaches zero, bit 0 of control register 0x71 is set and stays set. Writing 0x71 with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it set.
- R7: On expiry with configuration bit 6 set, wdt_rst_o goes high for exactly PULSE_CYCLES clock cycles. With bit 6 clear it stays low.
- R8: On expiry with configuration bit 4 set, pwr_good_o goes high for exactly PULSE_CYCLES clock cycles. With bit 4 clear it stays low.
- R9: irq_o is high exactly while the status flag is set, configuration bit 5 is set and configuration bits 3:0 are nonzero. irq_route_o always shows configuration bits 3:0.
- R10: After an expiry the count reads zero and further ticks neither restart the counter nor cause a second expiry.
- R11: Writing a new nonzero count while the watchdog is running restarts the count from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| wdt_rst_o | output | 1 | Reset pulse on expiry |
| pwr_good_o | output | 1 | Power-good pulse on expiry |
| irq_o | output | 1 | Interrupt request level |
| irq_route_o | output | 4 | Interrupt routing selection |

## Verification
The bench targets the minute prescaler: whether it strobes on the 60th tick and not the 59th, and whether a reload mid-minute clears it. A design that kept the prescaler phase would decrement early after a refresh. It writes the high byte alone to catch a design that reloads on either byte. Such a design would change the count before the low byte is written. It checks that a zero write stops the timer and that an expired counter stays idle. A design that wrapped to 0xFFFF or fired again would show a changed count or a second status set. Pulse widths are counted cycle by cycle against every combination of the enable bits, including disabled outputs staying low.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h71;
  localparam logic [7:0] ADDR_CFG  = 8'h72;
  localparam logic [7:0] ADDR_LSB  = 8'h73;
  localparam logic [7:0] ADDR_MSB  = 8'h74;

  localparam int CFG_SEC_BIT = 7;
  localparam int CFG_RST_BIT = 6;
  localparam int CFG_EVT_BIT = 5;
  localparam int CFG_PWR_BIT = 4;
  localparam int CTRL_STS_BIT = 0;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sts_set_i,
  output logic [DW-1:0] cfg_o,
  output logic          sts_o,
  output logic          reload_o,
  output logic [2*DW-1:0] reload_val_o
);
  logic [DW-1:0] cfg_q, msb_q;
  logic          sts_q;

  wire wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  wire wr_cfg  = wr_en_i && (addr_i == ADDR_CFG);
  wire wr_lsb  = wr_en_i && (addr_i == ADDR_LSB);
  wire wr_msb  = wr_en_i && (addr_i == ADDR_MSB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      msb_q <= '0;
      sts_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wdata_i;
      if (wr_msb) msb_q <= wdata_i;
      // set wins over a simultaneous clear
      if (sts_set_i) sts_q <= 1'b1;
      else if (wr_ctrl && wdata_i[CTRL_STS_BIT]) sts_q <= 1'b0;
    end
  end

  assign cfg_o        = cfg_q;
  assign sts_o        = sts_q;
  assign reload_o     = wr_lsb;
  assign reload_val_o = {msb_q, wdata_i};
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 60,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic strobe_o
);
  logic [PW-1:0] pre_q;
  wire last = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (clr_i)         pre_q <= '0;
    else if (en_i && tick_i) pre_q <= last ? '0 : pre_q + 1'b1;
  end

  assign strobe_o = en_i && tick_i && last;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reload_i,
  input  logic [CW-1:0] reload_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          active_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          active_q, expire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (reload_i) begin
        cnt_q    <= reload_val_i;
        active_q <= (reload_val_i != '0);
      end else if (active_q && dec_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          active_q <= 1'b0;
          expire_q <= 1'b1;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = active_q;
  assign expire_o = expire_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int WIDTH = 4,
  localparam int QW = $clog2(WIDTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  logic [QW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (trig_i)        left_q <= QW'(WIDTH);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/sm_watchdog.sv
module sm_watchdog
  import wdt_pkg::*;
#(
  parameter int PRESCALE     = 60,
  parameter int PULSE_CYCLES = 4,
  localparam int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          wdt_rst_o,
  output logic          pwr_good_o,
  output logic          irq_o,
  output logic [3:0]    irq_route_o
);
  logic [DW-1:0] cfg_q;
  logic          sts_q, reload, active_q, expire_q, min_strobe, dec;
  logic [CW-1:0] reload_val, cnt_q;
  logic [1:0]    trig, pulses;

  wdt_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .sts_set_i(expire_q), .cfg_o(cfg_q), .sts_o(sts_q),
    .reload_o(reload), .reload_val_o(reload_val)
  );

  wdt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i, .rst_ni, .clr_i(reload),
    .en_i(active_q && !cfg_q[CFG_SEC_BIT]),
    .tick_i, .strobe_o(min_strobe)
  );

  assign dec = cfg_q[CFG_SEC_BIT] ? tick_i : min_strobe;

  wdt_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .reload_i(reload), .reload_val_i(reload_val),
    .dec_i(dec), .cnt_o(cnt_q), .active_o(active_q), .expire_o(expire_q)
  );

  assign trig[0] = expire_q && cfg_q[CFG_RST_BIT];
  assign trig[1] = expire_q && cfg_q[CFG_PWR_BIT];

  for (genvar g = 0; g < 2; g++) begin : g_pulse
    wdt_pulse #(.WIDTH(PULSE_CYCLES)) u_pulse (
      .clk_i, .rst_ni, .trig_i(trig[g]), .pulse_o(pulses[g])
    );
  end

  assign wdt_rst_o   = pulses[0];
  assign pwr_good_o  = pulses[1];
  assign irq_route_o = cfg_q[3:0];
  assign irq_o       = sts_q && cfg_q[CFG_EVT_BIT] && (cfg_q[3:0] != 4'd0);

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {{(DW-1){1'b0}}, sts_q};
      ADDR_CFG:  rdata_o = cfg_q;
      ADDR_LSB:  rdata_o = cnt_q[DW-1:0];
      ADDR_MSB:  rdata_o = cnt_q[CW-1:DW];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sm_watchdog_chk.sv
module sm_watchdog_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reload,
  input logic          active_q,
  input logic          expire_q,
  input logic          sts_q,
  input logic [CW-1:0] cnt_q,
  input logic          wdt_rst_o,
  input logic          pwr_good_o,
  input logic          irq_o
);
  // R3
  step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!reload) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) - 1'b1);
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !reload) |=> $stable(cnt_q));
  // R6
  status_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q) |-> (cnt_q == '0));
  // R7
  rst_after_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(expire_q));
  // R8
  pwr_after_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_good_o) |-> $past(expire_q));
  // R9
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sts_q);
  // R10
  expire_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |=> !expire_q);
endmodule

bind sm_watchdog sm_watchdog_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reload(reload), .active_q(active_q),
  .expire_q(expire_q), .sts_q(sts_q), .cnt_q(cnt_q),
  .wdt_rst_o(wdt_rst_o), .pwr_good_o(pwr_good_o), .irq_o(irq_o)
);

// File: tb/sm_watchdog_tb_top.sv
module sm_watchdog_tb_top;
  localparam int PULSE = 4;
  localparam int PRE   = 60;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic       wdt_rst, pwr_good, irq;
  logic [3:0] irq_route;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sm_watchdog #(.PRESCALE(PRE), .PULSE_CYCLES(PULSE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_o(wdt_rst),
    .pwr_good_o(pwr_good), .irq_o(irq), .irq_route_o(irq_route)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_cnt(output int c);
    logic [7:0] lo, hi;
    rd(8'h73, lo); rd(8'h74, hi);
    c = {hi, lo};
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse_tick();
  endtask

  task automatic count_pulses(output int nr, output int np);
    nr = 0; np = 0;
    for (int i = 0; i < PULSE + 8; i++) begin
      @(negedge clk);
      if (wdt_rst) nr++;
      if (pwr_good) np++;
    end
  endtask

  function automatic int exp_irq(input logic [7:0] cfg, input bit sts);
    return (sts && cfg[5] && cfg[3:0] != 4'd0) ? 1 : 0;
  endfunction

  initial begin
    logic [7:0] d;
    int c, nr, np;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rst", wdt_rst, 0); check("R1 pwr", pwr_good, 0); check("R1 irq", irq, 0);
    rd(8'h71, d); check("R1 ctrl", d, 0);
    rd(8'h72, d); check("R1 cfg", d, 0);
    rst_n = 1'b1;
    rd_cnt(c); check("R1 cnt", c, 0);

    // R2 staging of high byte
    wr(8'h72, 8'h80);
    wr(8'h74, 8'h12);
    rd_cnt(c); check("R2 msb staged only", c, 0);
    wr(8'h73, 8'h34);
    rd_cnt(c); check("R2 full load", c, 16'h1234);
    // R3 seconds mode
    ticks(3);
    rd_cnt(c); check("R3 sec decrement", c, 16'h1231);
    // R11 refresh while running
    wr(8'h74, 8'h00); wr(8'h73, 8'h05);
    rd_cnt(c); check("R11 refresh", c, 5);
    ticks(2);
    rd_cnt(c); check("R11 after refresh", c, 3);
    // R5 zero stops
    wr(8'h73, 8'h00);
    ticks(5);
    rd_cnt(c); check("R5 stopped cnt", c, 0);
    rd(8'h71, d); check("R5 no expiry", d[0], 0);

    // R4 minute mode
    wr(8'h72, 8'h00);
    wr(8'h73, 8'h02);
    ticks(PRE - 1);
    rd_cnt(c); check("R4 59 ticks", c, 2);
    ticks(1);
    rd_cnt(c); check("R4 60th tick", c, 1);
    ticks(30);
    wr(8'h73, 8'h03);
    ticks(PRE - 1);
    rd_cnt(c); check("R4 prescaler cleared", c, 3);
    ticks(1);
    rd_cnt(c); check("R4 strobe after clear", c, 2);
    wr(8'h73, 8'h00);

    // R6 R7 R8 R9 R10 directed: all enables
    wr(8'h72, 8'hF5);
    check("R9 route", irq_route, 5);
    wr(8'h73, 8'h01);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    count_pulses(nr, np);
    check("R7 rst width", nr, PULSE);
    check("R8 pwr width", np, PULSE);
    rd(8'h71, d); check("R6 status set", d[0], 1);
    check("R9 irq on", irq, 1);
    wr(8'h71, 8'h00);
    rd(8'h71, d); check("R6 write0 keeps", d[0], 1);
    // R10 idle after expiry
    ticks(4);
    rd_cnt(c); check("R10 stays zero", c, 0);
    count_pulses(nr, np);
    check("R10 no second rst", nr, 0);
    wr(8'h71, 8'h01);
    rd(8'h71, d); check("R6 w1c", d[0], 0);
    check("R9 irq off", irq, 0);

    // randomized seconds-mode expiries
    for (int it = 0; it < 12; it++) begin
      logic [7:0] cfg;
      int n;
      cfg = 8'($urandom) | 8'h80;
      n   = $urandom_range(1, 10);
      wr(8'h72, cfg);
      check("R9 route rnd", irq_route, cfg[3:0]);
      wr(8'h74, 8'h00); wr(8'h73, 8'(n));
      for (int k = 1; k < n; k++) begin
        pulse_tick();
        rd_cnt(c); check("R3 rnd step", c, n - k);
      end
      pulse_tick();
      count_pulses(nr, np);
      check("R7 rnd rst", nr, cfg[6] ? PULSE : 0);
      check("R8 rnd pwr", np, cfg[4] ? PULSE : 0);
      rd(8'h71, d); check("R6 rnd sts", d[0], 1);
      check("R9 rnd irq", irq, exp_irq(cfg, 1'b1));
      wr(8'h71, 8'h01);
      check("R9 rnd irq clr", irq, 0);
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule